// File: doc/BRIEF.md
# Amplifier Mode and Protection Sequencer

This block is the control state machine for a two-channel switching power amplifier. A debounced mode request selects standby, mute or operate. The block turns that request into three enables for the power path: one that biases the power stage, one that lets the outputs switch, and one that releases the audio. On the way from standby to audio it runs an output-short test and two timed holds. All delays are whole milliseconds, counted from a tick that a parameter derives from the system clock.

Digital fault flags arrive from the analog sensors. Each fault class has its own recovery rule. Over-current retries after a fixed pause. Undervoltage and supply imbalance restart a fixed time after their flags clear. Overvoltage releases as soon as it clears. Over-temperature waits for a separate cooled flag. Every recovery re-enters the full wake and mute sequence. A status word records the cause of the most recent shutdown.

Top module: `amp_ctrl_seq`

## Requirements
- R1: After reset, `pwr_en_o`, `sw_en_o` and `unmute_o` are low and `fault_o` is zero.
- R2: `mode_req_i` encodes standby as 00, mute as 01 and operate as 1x. A non-standby request made in standby raises `pwr_en_o` two cycles later, which includes one short-test cycle. `sw_en_o` follows exactly WAKE_MS*CLKS_PER_MS cycles after `pwr_en_o` rises.
- R3: `unmute_o` rises only while operate is requested, and never earlier than UNMUTE_MS*CLKS_PER_MS cycles after `sw_en_o` rose. If operate is requested after that hold has elapsed, `unmute_o` rises on the next cycle. A mute request drops `unmute_o` on the next cycle, and a later operate request starts a fresh hold.
- R4: While the short test runs and `short_i` is high, `pwr_en_o` stays low and `fault_o` reads 6'b100000 (bit 5). Once `short_i` falls, `pwr_en_o` rises on the next cycle.
- R5: `short_i` has no effect once the short test has passed.
- R6: Over-current (`ocp_i`) drops all three enables on the next cycle and sets `fault_o` to bit 0. `pwr_en_o` comes back RETRY_MS*CLKS_PER_MS cycles after the trip.
- R7: Undervoltage (`uv_i`) drops all enables on the next cycle and sets `fault_o` to bit 1. `pwr_en_o` comes back RETRY_MS*CLKS_PER_MS cycles after `uv_i` and `imbal_i` are both low.
- R8: Overvoltage (`ov_i`) drops all enables on the next cycle and sets bit 2. `pwr_en_o` comes back on the cycle after `ov_i` falls.
- R9: Over-temperature (`ovt_i`) drops all enables on the next cycle and sets bit 3. A restart happens only on the cycle after `cool_i` is high, whatever the state of `ovt_i`.
- R10: After any recovery, `sw_en_o` and `unmute_o` again wait the full WAKE and UNMUTE holds.
- R11: A standby request drops all enables and clears `fault_o` on the next cycle, and it discards any running delay.
- R12: Supply imbalance (`imbal_i`) behaves like undervoltage but sets bit 4. When several faults coincide, the cause is picked in the order over-temperature, over-current, overvoltage, undervoltage, imbalance. `fault_o` holds only the latest cause.
- R13: `unmute_o` implies `sw_en_o`, and `sw_en_o` implies `pwr_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 2 | Mode request: 00 standby, 01 mute, 1x operate |
| short_i | input | 1 | An output is shorted to a rail (read only during the start-up test) |
| ocp_i | input | 1 | Over-current flag |
| uv_i | input | 1 | Undervoltage flag |
| ov_i | input | 1 | Overvoltage flag |
| imbal_i | input | 1 | Supply imbalance flag |
| ovt_i | input | 1 | Over-temperature flag |
| cool_i | input | 1 | Temperature below the lower hysteresis point |
| pwr_en_o | output | 1 | Power stage enable |
| sw_en_o | output | 1 | Output switching enable |
| unmute_o | output | 1 | Audio release |
| fault_o | output | 6 | Latched cause of the last shutdown (one-hot) |

## Verification
The enables are decoded from the registered state, so a change in an input shows one cycle later. Timed events are due exactly N*CLKS_PER_MS cycles after the edge that started the hold. For releases that wait on a flag, that edge is the last cycle the flag was still high. Inputs are driven on the falling edge. The bench then counts falling edges up to the awaited output change and compares the count with the figure computed from the parameters. A shortened tick keeps the counts small while each hold still spans its full number of milliseconds.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  typedef enum logic [3:0] {
    ST_STBY,
    ST_CHECK,
    ST_WAKE,
    ST_MUTE,
    ST_PLAY,
    ST_F_OCP,
    ST_F_SUP,
    ST_F_OV,
    ST_F_OVT
  } seq_state_e;

  localparam int FLT_W     = 6;
  localparam int FLT_OCP   = 0;
  localparam int FLT_UV    = 1;
  localparam int FLT_OV    = 2;
  localparam int FLT_OVT   = 3;
  localparam int FLT_IMB   = 4;
  localparam int FLT_SHORT = 5;

  localparam logic [1:0] MODE_STBY = 2'b00;
  localparam logic [1:0] MODE_MUTE = 2'b01;

  // one-hot cause, highest priority first
  function automatic logic [FLT_W-1:0] fault_pick(input logic ovt, input logic ocp,
                                                  input logic ov, input logic uv,
                                                  input logic imb);
    logic [FLT_W-1:0] r;
    r = '0;
    if (ovt)      r[FLT_OVT] = 1'b1;
    else if (ocp) r[FLT_OCP] = 1'b1;
    else if (ov)  r[FLT_OV]  = 1'b1;
    else if (uv)  r[FLT_UV]  = 1'b1;
    else if (imb) r[FLT_IMB] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/amp_seq_tick.sv
module amp_seq_tick #(
  parameter int CLKS_PER_MS = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_tick_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_tick_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
  parameter int MS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [MS_W-1:0] target_i,
  output logic            reached_o
);
  logic [MS_W-1:0] ms_q;
  logic            at_end;

  assign at_end = (ms_q == target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ms_q <= '0;
    else if (clr_i)             ms_q <= '0;
    else if (tick_i && !at_end) ms_q <= ms_q + 1'b1;
  end

  // level from the final tick onward; saturates until cleared
  assign reached_o = at_end || (tick_i && (ms_q == target_i - MS_W'(1)));

  p_ms_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= target_i);

  p_ms_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(ms_q));

endmodule

// File: rtl/amp_seq_fault_log.sv
module amp_seq_fault_log
  import amp_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [FLT_W-1:0] cause_i,
  output logic [FLT_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (clr_i)  word_o <= '0;
    else if (set_i)  word_o <= cause_i;
  end

  p_fault_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(word_o));

  p_fault_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (word_o == '0));

endmodule

// File: rtl/amp_ctrl_seq.sv
module amp_ctrl_seq
  import amp_seq_pkg::*;
#(
  parameter int CLKS_PER_MS = 125000,
  parameter int WAKE_MS     = 110,
  parameter int UNMUTE_MS   = 110,
  parameter int RETRY_MS    = 220
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_req_i,
  input  logic             short_i,
  input  logic             ocp_i,
  input  logic             uv_i,
  input  logic             ov_i,
  input  logic             imbal_i,
  input  logic             ovt_i,
  input  logic             cool_i,
  output logic             pwr_en_o,
  output logic             sw_en_o,
  output logic             unmute_o,
  output logic [FLT_W-1:0] fault_o
);
  localparam int MAX_A  = (WAKE_MS > UNMUTE_MS) ? WAKE_MS : UNMUTE_MS;
  localparam int MAX_MS = (MAX_A > RETRY_MS) ? MAX_A : RETRY_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  seq_state_e       state_q, state_d;
  logic             tick, tmr_clr, reached;
  logic [MS_W-1:0]  target;
  logic [FLT_W-1:0] cause, log_cause;
  logic             trip, log_set, want_stby, want_play, supply_bad;

  assign want_stby  = (mode_req_i == MODE_STBY);
  assign want_play  = mode_req_i[1];
  assign supply_bad = uv_i | imbal_i;
  assign cause      = fault_pick(ovt_i, ocp_i, ov_i, uv_i, imbal_i);

  always_comb begin
    state_d = state_q;
    trip    = 1'b0;
    if (want_stby) begin
      state_d = ST_STBY;
    end else begin
      unique case (state_q)
        ST_STBY:  state_d = ST_CHECK;
        ST_CHECK: if (!short_i) state_d = ST_WAKE;
        ST_WAKE, ST_MUTE, ST_PLAY: begin
          if (|cause) begin
            trip = 1'b1;
            if (cause[FLT_OVT])      state_d = ST_F_OVT;
            else if (cause[FLT_OCP]) state_d = ST_F_OCP;
            else if (cause[FLT_OV])  state_d = ST_F_OV;
            else                     state_d = ST_F_SUP;
          end else if (state_q == ST_WAKE) begin
            if (reached) state_d = ST_MUTE;
          end else if (state_q == ST_MUTE) begin
            if (reached && want_play) state_d = ST_PLAY;
          end else begin
            if (!want_play) state_d = ST_MUTE;
          end
        end
        ST_F_OCP: if (reached) state_d = ST_WAKE;
        ST_F_SUP: if (!supply_bad && reached) state_d = ST_WAKE;
        ST_F_OV:  if (!ov_i) state_d = ST_WAKE;
        ST_F_OVT: if (cool_i) state_d = ST_WAKE;
        default:  state_d = ST_STBY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STBY;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_MUTE:            target = MS_W'(UNMUTE_MS);
      ST_F_OCP, ST_F_SUP: target = MS_W'(RETRY_MS);
      default:            target = MS_W'(WAKE_MS);
    endcase
  end

  // restart delays on every state change; supply delay runs only once flags clear
  assign tmr_clr = (state_d != state_q) || ((state_q == ST_F_SUP) && supply_bad);

  amp_seq_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .tick_o(tick)
  );

  amp_seq_timer #(.MS_W(MS_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .tick_i   (tick),
    .target_i (target),
    .reached_o(reached)
  );

  always_comb begin
    log_cause = cause;
    log_set   = trip;
    if (state_q == ST_CHECK && short_i && !want_stby) begin
      log_cause = '0;
      log_cause[FLT_SHORT] = 1'b1;
      log_set   = 1'b1;
    end
  end

  amp_seq_fault_log u_log (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d == ST_STBY),
    .set_i  (log_set),
    .cause_i(log_cause),
    .word_o (fault_o)
  );

  assign pwr_en_o = (state_q == ST_WAKE) || (state_q == ST_MUTE) || (state_q == ST_PLAY);
  assign sw_en_o  = (state_q == ST_MUTE) || (state_q == ST_PLAY);
  assign unmute_o = (state_q == ST_PLAY);

  p_unmute_needs_sw_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmute_o |-> (sw_en_o && pwr_en_o));

  p_stby_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    want_stby |=> (!pwr_en_o && fault_o == '0));

  p_ocp_cut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o && ocp_i) |=> (!sw_en_o && !unmute_o && !pwr_en_o));

  p_short_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && short_i) |=> !pwr_en_o);

  p_ov_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_F_OV && !ov_i && !want_stby) |=> pwr_en_o);

  p_unmute_needs_play_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unmute_o) |-> ($past(mode_req_i[1]) && $past(sw_en_o)));

endmodule

// File: tb/amp_ctrl_seq_test.sv
module amp_ctrl_seq_test;
  localparam int C  = 4;
  localparam int WK = 110 * C;
  localparam int UM = 110 * C;
  localparam int RT = 220 * C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       short_f = 0, ocp = 0, uv = 0, ov = 0, imb = 0, ovt = 0, cool = 0;
  logic       pwr, sw, unm;
  logic [5:0] flt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  amp_ctrl_seq #(.CLKS_PER_MS(C)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_req_i(mode), .short_i(short_f),
    .ocp_i(ocp), .uv_i(uv), .ov_i(ov), .imbal_i(imb), .ovt_i(ovt), .cool_i(cool),
    .pwr_en_o(pwr), .sw_en_o(sw), .unmute_o(unm), .fault_o(flt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return pwr;
      1: return sw;
      2: return unm;
      default: return !pwr;
    endcase
  endfunction

  task automatic count_until(input int sel, output int n);
    n = 0;
    while (!sig(sel) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic to_standby(input string req);
    mode = 2'b00;
    @(negedge clk);
    chk({req, " outputs off"}, {pwr, sw, unm}, 0);
    chk({req, " fault cleared"}, flt, 0);
  endtask

  task automatic go_play();
    int n;
    mode = 2'b10;
    count_until(0, n);
    count_until(1, n);
    count_until(2, n);
  endtask

  task automatic t_reset();
    chk("R1 enables", {pwr, sw, unm}, 0);
    chk("R1 fault", flt, 0);
  endtask

  task automatic t_start_operate();
    int n;
    mode = 2'b10;
    count_until(0, n); chk("R2 pwr after request", n, 2);
    count_until(1, n); chk("R2 switching delay", n, WK);
    count_until(2, n); chk("R3 unmute delay", n, UM);
    to_standby("R11");
  endtask

  task automatic t_mute_then_operate();
    int n;
    mode = 2'b01;
    count_until(1, n);
    idle(600);
    chk("R3 mute keeps audio off", unm, 0);
    chk("R3 mute keeps switching", sw, 1);
    mode = 2'b10;
    count_until(2, n); chk("R3 late operate", n, 1);
    mode = 2'b01;
    @(negedge clk);
    chk("R3 back to mute", {sw, unm}, 2'b10);
    mode = 2'b10;
    count_until(2, n); chk("R3 fresh hold", n, UM);
    to_standby("R11");
  endtask

  task automatic t_short_check();
    int n;
    short_f = 1;
    mode = 2'b10;
    idle(50);
    chk("R4 held by short", pwr, 0);
    chk("R4 short bit", flt, 32);
    short_f = 0;
    count_until(0, n); chk("R4 release", n, 1);
    to_standby("R11");
  endtask

  task automatic t_short_ignored();
    go_play();
    short_f = 1;
    idle(20);
    chk("R5 audio kept", unm, 1);
    chk("R5 no fault", flt, 0);
    short_f = 0;
    to_standby("R11");
  endtask

  task automatic t_ocp();
    int n;
    go_play();
    ocp = 1;
    @(negedge clk);
    chk("R6 trip off", {pwr, sw, unm}, 0);
    chk("R6 fault bit0", flt, 1);
    ocp = 0;
    count_until(0, n); chk("R6 retry period", n, RT);
    count_until(1, n); chk("R10 wake after retry", n, WK);
    count_until(2, n); chk("R10 unmute after retry", n, UM);
    to_standby("R11");
  endtask

  task automatic t_supply(input bit use_imb);
    int n;
    go_play();
    if (use_imb) imb = 1; else uv = 1;
    @(negedge clk);
    chk(use_imb ? "R12 imbalance off" : "R7 uv off", {pwr, sw, unm}, 0);
    chk(use_imb ? "R12 imbalance bit4" : "R7 uv bit1", flt, use_imb ? 16 : 2);
    idle(1000);
    chk(use_imb ? "R12 held" : "R7 held", pwr, 0);
    imb = 0; uv = 0;
    count_until(0, n); chk(use_imb ? "R12 restart delay" : "R7 restart delay", n, RT);
    to_standby("R11");
  endtask

  task automatic t_ov();
    int n;
    go_play();
    ov = 1;
    @(negedge clk);
    chk("R8 off", {pwr, sw, unm}, 0);
    chk("R8 bit2", flt, 4);
    idle(30);
    ov = 0;
    count_until(0, n); chk("R8 immediate release", n, 1);
    count_until(1, n); chk("R10 wake after ov", n, WK);
    to_standby("R11");
  endtask

  task automatic t_ovt();
    int n;
    go_play();
    ovt = 1;
    @(negedge clk);
    chk("R9 off", {pwr, sw, unm}, 0);
    chk("R9 bit3", flt, 8);
    ovt = 0;
    idle(200);
    chk("R9 waits for cool", pwr, 0);
    cool = 1;
    count_until(0, n); chk("R9 restart on cool", n, 1);
    cool = 0;
    to_standby("R11");
  endtask

  task automatic t_standby_abort();
    int n;
    mode = 2'b10;
    count_until(0, n);
    idle(200);
    to_standby("R11 abort");
    mode = 2'b10;
    count_until(0, n); chk("R11 restart pwr", n, 2);
    count_until(1, n); chk("R11 full wake after abort", n, WK);
    to_standby("R11");
  endtask

  task automatic t_priority();
    int n;
    go_play();
    ocp = 1; uv = 1;
    @(negedge clk);
    chk("R12 ocp over uv", flt, 1);
    ocp = 0;
    count_until(0, n); chk("R12 retry", n, RT);
    @(negedge clk);
    chk("R12 uv retrips", pwr, 0);
    chk("R12 latest cause", flt, 2);
    uv = 0;
    to_standby("R11");
    go_play();
    ov = 1; ovt = 1;
    @(negedge clk);
    chk("R12 ovt over ov", flt, 8);
    ov = 0; ovt = 0;
    to_standby("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start_operate();
    t_mute_then_operate();
    t_short_check();
    t_short_ignored();
    t_ocp();
    t_supply(0);
    t_supply(1);
    t_ov();
    t_ovt();
    t_standby_abort();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule